// File: doc/BRIEF.md
# Program/Erase Busy Status Generator

This block sits in the read path of a parallel NOR-style flash model. It reports the progress of an internal program or erase operation. A start pulse carries the operation class: a word program, or a sector, block or chip erase. For a program it also carries the data word. The block then stays busy for a number of clock cycles chosen per operation class. That count stands in for the internal write time.

While the block is busy, every read returns completion status in two bits of the data word. Bit 7 is a polarity flag: for a program it is the inverse of the word's bit 7, and for an erase it is a constant 0. Bit 6 flips on each read and starts at 1. All other bits pass the array data through unchanged. When the count expires, the block raises a one-cycle done pulse and drops busy in the same cycle. From then on, reads return plain array data. Command decoding and the storage array belong to neighbouring logic. The neighbour fires the start pulse once the final write of a command sequence completes.

Top module: `pe_status_gen`

## Requirements
- R1: A start pulse while idle is accepted. Busy is high in the cycle after the start edge and stays high for exactly the configured cycle count of the operation class. The encoding of `op_i` is 00 program, 01 sector erase, 10 block erase, 11 chip erase.
- R2: During a program operation, bit 7 of every read returns the complement of bit 7 of the word supplied with the start pulse.
- R3: During any erase operation, bit 7 of every read returns 0.
- R4: When busy is low, a read returns `arr_data_i` unchanged on all bits. Read data is registered and appears in the cycle after the read strobe. `rd_data_o` holds its value when no strobe is present.
- R5: During an operation, bit 6 returns 1 on the first read after the start and inverts on each later read. Clock cycles without a read strobe do not change it.
- R6: Completion is a single-cycle `done_o` pulse. Busy is low in that same cycle.
- R7: A start pulse that arrives while busy is ignored. It does not change the duration, the operation class or the stored program bit.
- R8: During an operation, all read bits other than 7 and 6 pass `arr_data_i` through.
- R9: After a synchronous reset, busy, done and the read data register are all 0.
- R10: The bit-6 sequence restarts at 1 with every new operation, whatever parity the previous operation left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start of an internal operation |
| op_i | input | 2 | Operation class, sampled with start_i |
| prog_data_i | input | DATA_W | Word being programmed, sampled with start_i |
| rd_i | input | 1 | One-cycle read strobe |
| arr_data_i | input | DATA_W | Array read data for the current read |
| rd_data_o | output | DATA_W | Registered read data, with status overlay while busy |
| busy_o | output | 1 | Internal operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two cases can coincide. A read strobe can land on the clock edge where the count expires, and a start pulse can land on the same edge as a read or in the done cycle itself. The bench reads on every cycle of some runs, so one read always meets the final busy edge. It expects a status word from that read and plain array data from the very next one. It also issues a start together with a read from idle, which must return array data. Finally, it starts a new operation in the done cycle and expects busy to rise on the next cycle for the full new duration.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_BLK  = 2'b10,
    OP_CHIP = 2'b11
  } pe_op_e;

  function automatic logic op_is_erase(input logic [1:0] op);
    return op != OP_PROG;
  endfunction

endpackage

// File: rtl/pe_dur_timer.sv
module pe_dur_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             busy_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i && !busy_o) begin
        cnt_q  <= dur_i;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (cnt_q <= CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pe_toggle_bit.sv
module pe_toggle_bit (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic step_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst)          q_o <= 1'b1;
    else if (clear_i) q_o <= 1'b1;
    else if (step_i)  q_o <= ~q_o;
  end

endmodule

// File: rtl/pe_read_mux.sv
module pe_read_mux #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic              pbit7_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  logic [DATA_W-1:0] stat_w;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign stat_w[b] = erase_i ? 1'b0 : ~pbit7_i;
    end else if (b == TOG_BIT) begin : g_tog
      assign stat_w[b] = tog_i;
    end else begin : g_pass
      assign stat_w[b] = arr_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       data_o <= '0;
    else if (rd_i) data_o <= busy_i ? stat_w : arr_i;
  end

endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int unsigned PROG_CYC = 700,
  parameter int unsigned SECT_CYC = 300000,
  parameter int unsigned BLK_CYC  = 700000,
  parameter int unsigned CHIP_CYC = 1500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned MAX_AB  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_CD  = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept_w;
  logic [CNT_W-1:0] dur_w;
  logic             erase_q;
  logic             pbit7_q;
  logic             tog_w;

  assign accept_w = start_i & ~busy_o;

  always_comb begin
    unique case (op_i)
      OP_PROG: dur_w = CNT_W'(PROG_CYC);
      OP_SECT: dur_w = CNT_W'(SECT_CYC);
      OP_BLK:  dur_w = CNT_W'(BLK_CYC);
      default: dur_w = CNT_W'(CHIP_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      erase_q <= 1'b0;
      pbit7_q <= 1'b0;
    end else if (accept_w) begin
      erase_q <= op_is_erase(op_i);
      pbit7_q <= prog_data_i[7];
    end
  end

  pe_dur_timer #(.CNT_W(CNT_W)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept_w),
    .dur_i  (dur_w),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  pe_toggle_bit toggle_i (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept_w),
    .step_i  (rd_i & busy_o),
    .q_o     (tog_w)
  );

  pe_read_mux #(.DATA_W(DATA_W)) mux_i (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_i),
    .busy_i  (busy_o),
    .erase_i (erase_q),
    .pbit7_i (pbit7_q),
    .tog_i   (tog_w),
    .arr_i   (arr_data_i),
    .data_o  (rd_data_o)
  );

endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic              done_o
);

  logic er_q;

  always_ff @(posedge clk) begin
    if (rst)                      er_q <= 1'b0;
    else if (start_i && !busy_o)  er_q <= (op_i != 2'b00);
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r1_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  a_r4_idle_read: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !busy_o) |=> (rd_data_o == $past(arr_data_i)));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o));

  a_r3_erase_bit7: assert property (@(posedge clk) disable iff (rst)
    (rd_i && busy_o && er_q) |=> (rd_data_o[7] == 1'b0));

endmodule

bind pe_status_gen pe_status_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .op_i       (op_i),
  .rd_i       (rd_i),
  .arr_data_i (arr_data_i),
  .rd_data_o  (rd_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/pe_status_gen_tb_top.sv
module pe_status_gen_tb_top;

  localparam int DW = 16;
  localparam int PC = 5;
  localparam int SC = 9;
  localparam int BC = 13;
  localparam int CC = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic [1:0]    op_i;
  logic [DW-1:0] prog_data_i;
  logic          rd_i;
  logic [DW-1:0] arr_data_i;
  logic [DW-1:0] rd_data_o;
  logic          busy_o;
  logic          done_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pe_status_gen #(
    .DATA_W(DW), .PROG_CYC(PC), .SECT_CYC(SC), .BLK_CYC(BC), .CHIP_CYC(CC)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .prog_data_i(prog_data_i), .rd_i(rd_i), .arr_data_i(arr_data_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int dur_of(input logic [1:0] op);
    case (op)
      2'b00:   return PC;
      2'b01:   return SC;
      2'b10:   return BC;
      default: return CC;
    endcase
  endfunction

  function automatic logic rd_pat(input int pat, input int cyc);
    case (pat)
      0:       return 1'b1;
      1:       return (cyc % 2) == 1;
      2:       return (cyc % 3) == 0;
      default: return (cyc % 2) == 0;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [DW-1:0] pd, input int pat);
    int            dur = dur_of(op);
    logic          erase = (op != 2'b00);
    logic          tog = 1'b1;
    logic          first = 1'b1;
    logic          p_rd = 1'b0;
    logic          p_busy = 1'b0;
    logic          p_first = 1'b0;
    logic [DW-1:0] p_exp = '0;
    string         breq = (pat % 2 == 1) ? "R7" : "R1";
    for (int cyc = 0; cyc <= dur + 2; cyc++) begin
      logic          eb;
      logic [DW-1:0] arr;
      if (cyc > 0) begin
        chk(breq, "busy", {31'd0, busy_o}, {31'd0, (cyc >= 1 && cyc <= dur)});
        chk("R6", "done", {31'd0, done_o}, {31'd0, (cyc == dur + 1)});
        if (p_rd) begin
          if (p_busy) begin
            chk(erase ? "R3" : "R2", "bit7", {31'd0, rd_data_o[7]}, {31'd0, p_exp[7]});
            chk(p_first ? "R10" : "R5", "bit6", {31'd0, rd_data_o[6]}, {31'd0, p_exp[6]});
            chk("R8", "other bits", {16'd0, rd_data_o & 16'hFF3F}, {16'd0, p_exp & 16'hFF3F});
          end else begin
            chk("R4", "idle read", {16'd0, rd_data_o}, {16'd0, p_exp});
          end
        end
      end
      eb  = (cyc >= 1 && cyc <= dur);
      arr = 16'hA5C3 ^ DW'(cyc * 16'h1357) ^ DW'(pat * 16'h0101) ^ pd;
      rd_i       = rd_pat(pat, cyc);
      arr_data_i = arr;
      if (cyc == 0) begin
        start_i = 1'b1; op_i = op; prog_data_i = pd;
      end else if (pat % 2 == 1 && cyc == 2) begin
        start_i = 1'b1; op_i = ~op; prog_data_i = ~pd;
      end else begin
        start_i = 1'b0; op_i = 2'b00; prog_data_i = '0;
      end
      p_rd = rd_i; p_busy = eb; p_first = first;
      p_exp = arr;
      if (eb && rd_i) begin
        p_exp[7] = erase ? 1'b0 : ~pd[7];
        p_exp[6] = tog;
        tog   = ~tog;
        first = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0; rd_i = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    bad++; total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    rst = 1'b1; start_i = 1'b0; op_i = 2'b00; prog_data_i = '0;
    rd_i = 1'b0; arr_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R9", "reset busy", {31'd0, busy_o}, 32'd0);
    chk("R9", "reset done", {31'd0, done_o}, 32'd0);
    chk("R9", "reset data", {16'd0, rd_data_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int o = 0; o < 4; o++)
      for (int p = 0; p < 4; p++)
        for (int d = 0; d < 2; d++)
          run_op(2'(o), (d == 0) ? 16'h00F0 : 16'h0F0F, p);

    // start in the done cycle of a program
    start_i = 1'b1; op_i = 2'b00; prog_data_i = 16'h0080;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (!done_o && cnt < 40) begin @(negedge clk); cnt++; end
    chk("R6", "done seen", {31'd0, done_o}, 32'd1);
    start_i = 1'b1; op_i = 2'b11;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1", "busy after start in done cycle", {31'd0, busy_o}, 32'd1);
    chk("R6", "done cleared", {31'd0, done_o}, 32'd0);
    cnt = 0;
    while (busy_o && cnt < 60) begin @(negedge clk); cnt++; end
    chk("R1", "chip erase length", cnt, CC);
    chk("R6", "done after chip", {31'd0, done_o}, 32'd1);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule